// File: doc/BRIEF.md
# TAP Macro Executor

This block plays one TAP macro onto a target scan chain. A start pulse captures a 9-bit macro word, a macro type (State or BIST), two tail enables, a pre-shift clock count, a BIST count length, a default TDO level and a flag that says whether the run belongs to a sequencer pass. The block then drives TCK enable, TMS and TDO toward the chain for as many clocks as the captured values call for.

A run has three parts. The pre-shift phase walks TMS through macro bits 0 to 6, one per clock, and wraps back to bit 0 while the count is not yet used up. The type-specific tail follows: bit 7 and bit 8 of the macro, each behind its own enable, with TDO held in State type and forced to the default level in BIST type. The run then ends. If the bit-8 step ran, the block first hands the chain to an external data-shift engine and waits for its acknowledge. A completion pulse closes the run, and in sequencer mode that pulse also asks for the vector repeat count to be decremented.

Top module: `tap_macro_exec`

## Requirements
- R1: After reset and whenever no run is active, tck_en_o, tms_o, shift_req_o, done_o and rpt_dec_o are 0, and tdo_o starts at 0 after reset.
- R2: With pre-shift count P > 0, the first P cycles of a run have tck_en_o = 1 and tms_o = macro bit (i mod 7) in cycle i (i = 0..P-1), so bits 0..6 repeat cyclically.
- R3: During pre-shift, tdo_o keeps the value it had before the run.
- R4: In State type (macro_type_i = 0) with bit7_en_i = 1, one cycle follows pre-shift with tck_en_o = 1, tms_o = macro bit 7 and tdo_o unchanged.
- R5: In BIST type (macro_type_i = 1) with bit7_en_i = 1, L = bist_len_i cycles follow pre-shift with tck_en_o = 1, tms_o = macro bit 7 and tdo_o = tdo_dflt_i; with L = 0 this step takes no cycle.
- R6: With bit8_en_i = 1, one cycle follows with tck_en_o = 1 and tms_o = macro bit 8. In that cycle tdo_o is unchanged in State type and equals tdo_dflt_i in BIST type.
- R7: After the bit-8 cycle, shift_req_o stays 1 with tck_en_o = 0 and tms_o = 0 up to and including the cycle in which shift_done_i is sampled 1. The done cycle follows.
- R8: Without bit8_en_i, the done cycle directly follows the last cycle of pre-shift or tail. With neither phase active, it is the first cycle after start.
- R9: done_o is a single-cycle pulse per run. rpt_dec_o is 1 in that cycle only when seq_mode_i was 1 at start, and is 0 otherwise.
- R10: tdo_o keeps the last value it drove across runs and idle cycles; it changes only in BIST tail cycles.
- R11: start_i and all run inputs are ignored while a run is active; the run uses the values captured at start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run; sampled only while idle |
| macro_i | input | 9 | Macro word: bits 0..6 pre-shift TMS, bit 7 and bit 8 tail TMS |
| macro_type_i | input | 1 | 0 = State, 1 = BIST |
| bit7_en_i | input | 1 | Enable the bit-7 tail step |
| bit8_en_i | input | 1 | Enable the bit-8 tail step and the shift handoff |
| pre_cnt_i | input | PRE_W | Pre-shift clock count |
| bist_len_i | input | LEN_W | BIST count length for the bit-7 step |
| tdo_dflt_i | input | 1 | Default TDO level for BIST tails |
| seq_mode_i | input | 1 | 1 = sequencer run, 0 = single vector |
| shift_done_i | input | 1 | Acknowledge from the data-shift engine |
| tck_en_o | output | 1 | TCK enable toward the chain |
| tms_o | output | 1 | TMS toward the chain |
| tdo_o | output | 1 | TDO toward the chain |
| shift_req_o | output | 1 | Data-shift handoff request |
| done_o | output | 1 | Run completion pulse |
| rpt_dec_o | output | 1 | Decrement vector repeat count (sequencer mode) |

## Verification
The hardest case to reach is the TDO hold across run boundaries. It shows up only when a BIST tail has moved the line to the default level and a later State run or pre-shift must keep that level. The stimulus therefore chains runs with different default levels and types back to back. A reference model carries the last driven TDO level from one run to the next. Pre-shift counts above seven, exactly seven and zero exercise the bit wrap, and a noise start with altered inputs is injected during a long run.

// File: rtl/tme_pkg.sv
package tme_pkg;
  localparam int MACRO_W  = 9;
  localparam int PRE_BITS = 7;
  localparam int SEL_W    = $clog2(PRE_BITS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_B7, ST_B8, ST_SHIFT, ST_FIN
  } tme_state_e;
endpackage

// File: rtl/tme_pre_gen.sv
module tme_pre_gen
  import tme_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             run_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (load_i) begin
      cnt_q <= cnt_i;
      sel_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q - 1'b1;
      // wrap over the seven pre-shift bits
      sel_q <= (sel_q == SEL_W'(PRE_BITS - 1)) ? '0 : sel_q + 1'b1;
    end
  end

  assign sel_o  = sel_q;
  assign last_o = (cnt_q == CNT_W'(1));

  // R2
  pre_no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q != '0));
endmodule

// File: rtl/tme_len_cnt.sv
module tme_len_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             run_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= len_i;
    else if (run_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/tap_macro_exec.sv
module tap_macro_exec
  import tme_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int LEN_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [MACRO_W-1:0] macro_i,
  input  logic               macro_type_i,
  input  logic               bit7_en_i,
  input  logic               bit8_en_i,
  input  logic [PRE_W-1:0]   pre_cnt_i,
  input  logic [LEN_W-1:0]   bist_len_i,
  input  logic               tdo_dflt_i,
  input  logic               seq_mode_i,
  input  logic               shift_done_i,
  output logic               tck_en_o,
  output logic               tms_o,
  output logic               tdo_o,
  output logic               shift_req_o,
  output logic               done_o,
  output logic               rpt_dec_o
);
  tme_state_e st_q, st_d;
  logic [MACRO_W-1:0] macro_q;
  logic bist_q, b7_q, b8_q, len_nz_q, dflt_q, seq_q, tdo_q;
  logic [SEL_W-1:0] pre_sel;
  logic pre_last, len_last, accept;

  assign accept = (st_q == ST_IDLE) && start_i;

  function automatic tme_state_e tail_entry(logic bist, logic b7, logic b8, logic len_nz);
    if (b7 && (!bist || len_nz)) return ST_B7;
    if (b8)                      return ST_B8;
    return ST_FIN;
  endfunction

  tme_pre_gen #(.CNT_W(PRE_W)) u_pre (
    .clk_i, .rst_ni,
    .load_i (accept),
    .cnt_i  (pre_cnt_i),
    .run_i  (st_q == ST_PRE),
    .sel_o  (pre_sel),
    .last_o (pre_last)
  );

  tme_len_cnt #(.CNT_W(LEN_W)) u_len (
    .clk_i, .rst_ni,
    .load_i (accept),
    .len_i  (bist_len_i),
    .run_i  (st_q == ST_B7),
    .last_o (len_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i)
                  st_d = (pre_cnt_i != '0) ? ST_PRE
                       : tail_entry(macro_type_i, bit7_en_i, bit8_en_i, bist_len_i != '0);
      ST_PRE:   if (pre_last) st_d = tail_entry(bist_q, b7_q, b8_q, len_nz_q);
      ST_B7:    if (!bist_q || len_last) st_d = b8_q ? ST_B8 : ST_FIN;
      ST_B8:    st_d = ST_SHIFT;
      ST_SHIFT: if (shift_done_i) st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      macro_q  <= '0;
      bist_q   <= 1'b0;
      b7_q     <= 1'b0;
      b8_q     <= 1'b0;
      len_nz_q <= 1'b0;
      dflt_q   <= 1'b0;
      seq_q    <= 1'b0;
      tdo_q    <= 1'b0;
    end else begin
      st_q  <= st_d;
      tdo_q <= tdo_o;
      if (accept) begin
        macro_q  <= macro_i;
        bist_q   <= macro_type_i;
        b7_q     <= bit7_en_i;
        b8_q     <= bit8_en_i;
        len_nz_q <= (bist_len_i != '0);
        dflt_q   <= tdo_dflt_i;
        seq_q    <= seq_mode_i;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_PRE:  tms_o = macro_q[pre_sel];
      ST_B7:   tms_o = macro_q[7];
      ST_B8:   tms_o = macro_q[8];
      default: tms_o = 1'b0;
    endcase
  end

  assign tck_en_o    = (st_q == ST_PRE) || (st_q == ST_B7) || (st_q == ST_B8);
  assign tdo_o       = (bist_q && ((st_q == ST_B7) || (st_q == ST_B8))) ? dflt_q : tdo_q;
  assign shift_req_o = (st_q == ST_SHIFT);
  assign done_o      = (st_q == ST_FIN);
  assign rpt_dec_o   = done_o && seq_q;

  // R3
  pre_tdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRE) |-> $stable(tdo_o));
  // R7
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_req_o && !shift_done_i) |=> shift_req_o);
  // R7
  shift_no_tck_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_req_o |-> !tck_en_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  dec_in_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_dec_o |-> done_o);
  // R10
  tdo_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tdo_o) |-> (bist_q && tck_en_o));
endmodule

// File: tb/tap_macro_exec_bench.sv
`timescale 1ns/1ps
module tap_macro_exec_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, mtype = 0, b7en = 0, b8en = 0, dflt = 0, seqm = 0, sdone = 0;
  logic [8:0] macro = '0;
  logic [7:0] pre = '0, len = '0;
  logic tck_en, tms, tdo, sreq, done, dec;

  int errors = 0, checks = 0;
  bit tdo_m = 0;

  typedef struct {
    bit tck, tms, tdo, req, done, dec, ack;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  tap_macro_exec u_tap_macro_exec (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .macro_i(macro),
    .macro_type_i(mtype), .bit7_en_i(b7en), .bit8_en_i(b8en),
    .pre_cnt_i(pre), .bist_len_i(len), .tdo_dflt_i(dflt),
    .seq_mode_i(seqm), .shift_done_i(sdone),
    .tck_en_o(tck_en), .tms_o(tms), .tdo_o(tdo),
    .shift_req_o(sreq), .done_o(done), .rpt_dec_o(dec)
  );

  task automatic cmp(exp_t e);
    logic [5:0] act, ex;
    act = {tck_en, tms, tdo, sreq, done, dec};
    ex  = {e.tck, e.tms, e.tdo, e.req, e.done, e.dec};
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: {tck,tms,tdo,req,done,dec} actual=%b expected=%b at %0t",
               e.tag, act, ex, $time);
    end
  endtask

  function automatic exp_t mk(bit tck, bit tms_v, bit tdo_v, bit req, bit dn,
                              bit dc, bit ack, string tag);
    exp_t e;
    e.tck = tck; e.tms = tms_v; e.tdo = tdo_v; e.req = req;
    e.done = dn; e.dec = dc; e.ack = ack; e.tag = tag;
    return e;
  endfunction

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(mk(0, 0, tdo_m, 0, 0, 0, 0, "R1"));
    end
  endtask

  task automatic run(bit [8:0] m, bit bist, bit e7, bit e8, int p, int l,
                     bit d, bit s, int wait_n, int noise_at);
    int cyc;
    for (int i = 0; i < p; i++) q.push_back(mk(1, m[i % 7], tdo_m, 0, 0, 0, 0, "R2"));
    if (e7) begin
      if (!bist) q.push_back(mk(1, m[7], tdo_m, 0, 0, 0, 0, "R4"));
      else begin
        for (int i = 0; i < l; i++) q.push_back(mk(1, m[7], d, 0, 0, 0, 0, "R5"));
        if (l > 0) tdo_m = d;
      end
    end
    if (e8) begin
      if (bist) tdo_m = d;
      q.push_back(mk(1, m[8], tdo_m, 0, 0, 0, 0, "R6"));
      for (int j = 0; j <= wait_n; j++)
        q.push_back(mk(0, 0, tdo_m, 1, 0, 0, j == wait_n, "R7"));
    end
    q.push_back(mk(0, 0, tdo_m, 0, 1, s, 0, (e8 || p > 0 || e7) ? "R9" : "R8"));

    @(negedge clk);
    start = 1; macro = m; mtype = bist; b7en = e7; b8en = e8;
    pre = 8'(p); len = 8'(l); dflt = d; seqm = s;
    cyc = 0;
    while (q.size() > 0) begin
      exp_t e;
      @(negedge clk);
      start = 0;
      e = q.pop_front();
      cmp(e);
      sdone = e.ack;
      if (cyc == noise_at) begin
        // R11: disturb all run inputs mid-run
        start = 1; macro = ~m; mtype = ~bist; b7en = ~e7; b8en = ~e8;
        pre = 8'd3; len = 8'd2; dflt = ~d; seqm = ~s;
      end
      cyc++;
    end
    @(negedge clk);
    start = 0; sdone = 0;
    cmp(mk(0, 0, tdo_m, 0, 0, 0, 0, "R11"));
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp(mk(0, 0, 0, 0, 0, 0, 0, "R1"));
    rst_n = 1;
    idle_cycles(3);
    // State, short pre-shift, both tail steps, sequencer mode
    run(9'b1_0_1011001, 0, 1, 1, 3, 0, 1, 1, 2, -1);
    idle_cycles(2);
    // BIST, pre-shift wraps past bit 6, bit-7 count, no bit 8 (R5 R10)
    run(9'b0_1_0110101, 1, 1, 0, 10, 4, 1, 0, 0, -1);
    idle_cycles(2);
    // State, no pre-shift, bit-7 only: tdo keeps 1 (R3 R10)
    run(9'b0_1_1111111, 0, 1, 0, 0, 0, 0, 1, 0, -1);
    // BIST, zero count length skips bit 7, bit 8 drives default 0
    run(9'b1_1_0000000, 1, 1, 1, 0, 0, 0, 0, 1, -1);
    idle_cycles(1);
    // BIST, long pre-shift with noise start, immediate shift ack (R11)
    run(9'b1_0_1100110, 1, 1, 1, 15, 3, 1, 1, 0, 5);
    // State, pre-shift keeps tdo=1, no tail
    run(9'b0_0_0101010, 0, 0, 0, 7, 0, 0, 0, 0, 2);
    // Nothing to do: done right after start (R8)
    run(9'b1_1_1111111, 0, 0, 0, 0, 0, 1, 1, 0, -1);
    // Shift handoff with long wait in State type
    run(9'b1_0_0000001, 0, 0, 1, 1, 0, 1, 0, 6, 3);
    idle_cycles(3);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule